// File: doc/BRIEF.md
# Back-Invalidate Snoop Filter Controller

This block is the coherence engine on the device side of a memory shared by several hosts. It keeps an inclusive snoop filter: a set-associative table whose entries each hold a line tag, a sharer bit per host and a line state (Invalid, Shared or Exclusive). Every line that any host may cache has an entry that names that host. Requests are handled one at a time. A shared read adds the requester to the sharer set and returns data without snooping anyone. An exclusive request first sends a back-invalidate snoop to each other host that holds the line. It counts their acknowledgements, rewrites the entry so that the requester is the sole owner, and only then reads memory and returns data together with ownership.

A miss in a set whose ways are all in use evicts a victim, chosen by a per-set round-robin pointer. All sharers of the victim are back-invalidated before its way is reused, so the filter stays inclusive. The request channel, the per-host snoop channel and the response channel use valid/ready. A transfer happens on a rising edge where both valid and ready are high. A valid, once raised, stays high with its payload unchanged until it is accepted. Acknowledgements are single-cycle pulses that are always accepted. Memory is read through a plain port with a fixed latency of one cycle.

Top module: `bisf_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1 and snp_valid, rsp_valid and err_ack are all 0.
- R2: A shared request (req_excl=0) that does not need to evict a victim issues no snoop at all and adds the requester to the line's sharer set. This also holds when another host owns the line exclusively.
- R3: An exclusive request (req_excl=1) that hits snoops exactly the hosts whose sharer bit is set, excluding the requester. Bit h of snp_valid addresses host h, and every snoop carries the request address on snp_addr.
- R4: Once an exclusive request has been granted, the requester is the only sharer of the line. A later exclusive request from another host then snoops that host alone.
- R5: The block returns no response while any acknowledgement is still outstanding. The outstanding count is loaded with the number of snoops issued and falls by one for each expected acknowledgement.
- R6: An ack_valid bit from a host that is not currently awaited raises err_ack for exactly one cycle, on the cycle after the pulse. The ack does not change the count.
- R7: The set index is addr[SET_W-1:0] and the tag is the rest of the address. On a miss, the block takes the lowest-numbered free way. If the set is full, it evicts the way at that set's round-robin pointer, which starts at 0 and advances by one (wrapping) on each eviction. It snoops every sharer of the victim with the victim's address {tag, set} before granting, and the new entry lists only the requester.
- R8: req_ready is low from the cycle after a request is accepted until the response has been accepted.
- R9: A response that has been raised holds rsp_host, rsp_excl and rsp_data until rsp_ready is seen. rsp_data is the mem_rd_data returned one cycle after mem_rd_en was raised with mem_rd_addr equal to the request address.
- R10: Each snp_valid bit stays high until the matching snp_ready bit accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_host | input | HID_W | Requesting host number |
| req_excl | input | 1 | 1 = exclusive ownership wanted, 0 = shared read |
| req_addr | input | ADDR_W | Line address |
| snp_valid | output | HOSTS | Back-invalidate snoop pending, one bit per host |
| snp_ready | input | HOSTS | Host accepts its snoop |
| snp_addr | output | ADDR_W | Line address being invalidated |
| ack_valid | input | HOSTS | Invalidate acknowledgement pulse, one bit per host |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Read data, valid one cycle after the strobe |
| rsp_valid | output | 1 | Grant with data offered |
| rsp_ready | input | 1 | Requester accepts the grant |
| rsp_host | output | HID_W | Host receiving the grant |
| rsp_excl | output | 1 | Grant carries exclusive ownership |
| rsp_data | output | DATA_W | Line data |
| err_ack | output | 1 | One-cycle flag for an unexpected acknowledgement |

## Verification
A bad sharer bit in the filter cannot be seen when it is written. It surfaces only on a later exclusive request or on the eviction of that line, as a snp_valid pattern with one bit too many or too few. The bench therefore replays long request mixes against an arithmetic model of tags, sharer sets and round-robin pointers, and checks every snoop mask. A fault in the acknowledgement count shows within the same request, either as a grant that arrives before the last ack or as a request that never completes. A wrong victim pointer shows as a wrong snp_addr at the next conflict miss in that set.

// File: rtl/bisf_pkg.sv
package bisf_pkg;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_LOOK  = 3'd1,
    CS_SNOOP = 3'd2,
    CS_UPD   = 3'd3,
    CS_MEM   = 3'd4,
    CS_RESP  = 3'd5
  } ctrl_st_e;

endpackage

// File: rtl/bisf_filter.sv
module bisf_filter
  import bisf_pkg::*;
#(
  parameter int HOSTS = 4,
  parameter int SET_W = 2,
  parameter int TAG_W = 14,
  parameter int WAYS  = 2,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [HOSTS-1:0] hit_sh,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_need,
  output logic [TAG_W-1:0] vic_tag,
  output logic [HOSTS-1:0] vic_sh,
  input  logic             adv_rr,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [HOSTS-1:0] wr_sh,
  input  line_st_e         wr_st
);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [HOSTS-1:0] sh_q  [SETS][WAYS];
  line_st_e         st_q  [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  logic [WAYS-1:0] way_hit;
  logic [WAYS-1:0] way_free;

  for (genvar g = 0; g < WAYS; g++) begin : g_way_cmp
    assign way_hit[g]  = (st_q[lk_set][g] != LN_INV) && (tag_q[lk_set][g] == lk_tag);
    assign way_free[g] = (st_q[lk_set][g] == LN_INV);
  end

  logic [WAY_W-1:0] free_way;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w])  hit_way  = WAY_W'(w);
      if (way_free[w]) free_way = WAY_W'(w);
    end
  end

  assign hit      = |way_hit;
  assign hit_sh   = sh_q[lk_set][hit_way];
  assign vic_need = !hit && !(|way_free);
  assign vic_way  = (|way_free) ? free_way : rr_q[lk_set];
  assign vic_tag  = tag_q[lk_set][rr_q[lk_set]];
  assign vic_sh   = sh_q[lk_set][rr_q[lk_set]];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          sh_q[s][w]  <= '0;
          st_q[s][w]  <= LN_INV;
        end
      end else begin
        if (adv_rr && (lk_set == SET_W'(s))) begin
          rr_q[s] <= (rr_q[s] == WAY_W'(WAYS - 1)) ? '0 : rr_q[s] + 1'b1;
        end
        if (wr_en && (lk_set == SET_W'(s))) begin
          tag_q[s][wr_way] <= wr_tag;
          sh_q[s][wr_way]  <= wr_sh;
          st_q[s][wr_way]  <= wr_st;
        end
      end
    end
  end

endmodule

// File: rtl/bisf_ack_tracker.sv
module bisf_ack_tracker #(
  parameter int HOSTS = 4,
  localparam int CNT_W = $clog2(HOSTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [HOSTS-1:0] load_mask,
  input  logic [HOSTS-1:0] ack_valid,
  output logic [CNT_W-1:0] left,
  output logic             err_pulse
);

  logic [HOSTS-1:0] await_q;
  logic [HOSTS-1:0] good;

  assign good = ack_valid & await_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      await_q   <= '0;
      left      <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_pulse <= |(ack_valid & ~await_q);
      if (load) begin
        await_q <= load_mask;
        left    <= CNT_W'($countones(load_mask));
      end else begin
        await_q <= await_q & ~good;
        left    <= left - CNT_W'($countones(good));
      end
    end
  end

endmodule

// File: rtl/bisf_snoop_issue.sv
module bisf_snoop_issue #(
  parameter int HOSTS  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HOSTS-1:0]  load_mask,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [HOSTS-1:0]  snp_ready,
  output logic [HOSTS-1:0]  snp_valid,
  output logic [ADDR_W-1:0] snp_addr,
  output logic              drained
);

  logic [HOSTS-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      snp_addr <= '0;
    end else if (load) begin
      pend_q   <= load_mask;
      snp_addr <= load_addr;
    end else begin
      pend_q <= pend_q & ~snp_ready;
    end
  end

  assign snp_valid = pend_q;
  assign drained   = (pend_q == '0);

endmodule

// File: rtl/bisf_ctrl.sv
module bisf_ctrl
  import bisf_pkg::*;
#(
  parameter int HOSTS  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SET_W  = 2,
  parameter int WAYS   = 2,
  localparam int HID_W = (HOSTS > 1) ? $clog2(HOSTS) : 1,
  localparam int TAG_W = ADDR_W - SET_W,
  localparam int CNT_W = $clog2(HOSTS + 1),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [HID_W-1:0]  req_host,
  input  logic              req_excl,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [HOSTS-1:0]  snp_valid,
  input  logic [HOSTS-1:0]  snp_ready,
  output logic [ADDR_W-1:0] snp_addr,
  input  logic [HOSTS-1:0]  ack_valid,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [HID_W-1:0]  rsp_host,
  output logic              rsp_excl,
  output logic [DATA_W-1:0] rsp_data,
  output logic              err_ack
);

  ctrl_st_e          st_q;
  logic [HID_W-1:0]  r_host;
  logic              r_excl;
  logic [ADDR_W-1:0] r_addr;
  logic [WAY_W-1:0]  r_way;
  logic [DATA_W-1:0] r_data;

  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [HOSTS-1:0]  hit_sh;
  logic [WAY_W-1:0]  vic_way;
  logic              vic_need;
  logic [TAG_W-1:0]  vic_tag;
  logic [HOSTS-1:0]  vic_sh;

  logic [HOSTS-1:0]  req_oh;
  logic [HOSTS-1:0]  lk_mask;
  logic [ADDR_W-1:0] lk_saddr;
  logic [HOSTS-1:0]  new_sh;
  line_st_e          new_st;
  logic              snp_load;
  logic              drained;
  logic [CNT_W-1:0]  ack_left;

  assign req_oh = HOSTS'(1) << r_host;

  // Snoop set decided at lookup: other sharers on an exclusive hit, or every
  // sharer of the victim when a full set must give up a way.
  always_comb begin
    lk_mask  = '0;
    lk_saddr = r_addr;
    if (hit) begin
      if (r_excl) lk_mask = hit_sh & ~req_oh;
    end else if (vic_need) begin
      lk_mask  = vic_sh;
      lk_saddr = {vic_tag, r_addr[SET_W-1:0]};
    end
  end

  always_comb begin
    if (hit && !r_excl) new_sh = hit_sh | req_oh;
    else                new_sh = req_oh;
    new_st = r_excl ? LN_EXC : LN_SHR;
  end

  assign snp_load = (st_q == CS_LOOK) && (lk_mask != '0);

  bisf_filter #(
    .HOSTS(HOSTS), .SET_W(SET_W), .TAG_W(TAG_W), .WAYS(WAYS)
  ) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_set   (r_addr[SET_W-1:0]),
    .lk_tag   (r_addr[ADDR_W-1:SET_W]),
    .hit      (hit),
    .hit_way  (hit_way),
    .hit_sh   (hit_sh),
    .vic_way  (vic_way),
    .vic_need (vic_need),
    .vic_tag  (vic_tag),
    .vic_sh   (vic_sh),
    .adv_rr   ((st_q == CS_LOOK) && vic_need),
    .wr_en    (st_q == CS_UPD),
    .wr_way   (r_way),
    .wr_tag   (r_addr[ADDR_W-1:SET_W]),
    .wr_sh    (new_sh),
    .wr_st    (new_st)
  );

  bisf_snoop_issue #(.HOSTS(HOSTS), .ADDR_W(ADDR_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (snp_load),
    .load_mask (lk_mask),
    .load_addr (lk_saddr),
    .snp_ready (snp_ready),
    .snp_valid (snp_valid),
    .snp_addr  (snp_addr),
    .drained   (drained)
  );

  bisf_ack_tracker #(.HOSTS(HOSTS)) u_acks (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (snp_load),
    .load_mask (lk_mask),
    .ack_valid (ack_valid),
    .left      (ack_left),
    .err_pulse (err_ack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      r_host <= '0;
      r_excl <= 1'b0;
      r_addr <= '0;
      r_way  <= '0;
      r_data <= '0;
    end else begin
      case (st_q)
        CS_IDLE: if (req_valid) begin
          r_host <= req_host;
          r_excl <= req_excl;
          r_addr <= req_addr;
          st_q   <= CS_LOOK;
        end
        CS_LOOK: begin
          r_way <= hit ? hit_way : vic_way;
          st_q  <= (lk_mask != '0) ? CS_SNOOP : CS_UPD;
        end
        CS_SNOOP: if (drained && (ack_left == '0)) st_q <= CS_UPD;
        CS_UPD:   st_q <= CS_MEM;
        CS_MEM: begin
          r_data <= mem_rd_data;
          st_q   <= CS_RESP;
        end
        CS_RESP: if (rsp_ready) st_q <= CS_IDLE;
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  assign req_ready   = (st_q == CS_IDLE);
  assign mem_rd_en   = (st_q == CS_UPD);
  assign mem_rd_addr = r_addr;
  assign rsp_valid   = (st_q == CS_RESP);
  assign rsp_host    = r_host;
  assign rsp_excl    = r_excl;
  assign rsp_data    = r_data;

endmodule

// File: rtl/bisf_ctrl_chk.sv
module bisf_ctrl_chk #(
  parameter int HOSTS  = 4,
  parameter int DATA_W = 32,
  parameter int HID_W  = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [HOSTS-1:0]  snp_valid,
  input logic [HOSTS-1:0]  snp_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [HID_W-1:0]  rsp_host,
  input logic [DATA_W-1:0] rsp_data,
  input logic [CNT_W-1:0]  outstanding
);

  // R5
  grant_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (outstanding == '0));

  // R5
  ack_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= CNT_W'(HOSTS));

  // R8
  busy_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || (snp_valid != '0)) |-> !req_ready);

  // R10
  snoop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((snp_valid & ~snp_ready) != '0) |=>
      (($past(snp_valid) & ~$past(snp_ready) & ~snp_valid) == '0));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_host)));

endmodule

bind bisf_ctrl bisf_ctrl_chk #(
  .HOSTS(HOSTS), .DATA_W(DATA_W), .HID_W(HID_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .snp_valid   (snp_valid),
  .snp_ready   (snp_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_host    (rsp_host),
  .rsp_data    (rsp_data),
  .outstanding (ack_left)
);

// File: tb/bisf_ctrl_test.sv
module bisf_ctrl_test;
  localparam int H  = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_host = '0;
  logic          req_excl = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [H-1:0]  snp_valid;
  logic [H-1:0]  snp_ready = '1;
  logic [AW-1:0] snp_addr;
  logic [H-1:0]  ack_valid = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [1:0]    rsp_host;
  logic          rsp_excl;
  logic [DW-1:0] rsp_data;
  logic          err_ack;

  int n_chk = 0;
  int n_fail = 0;

  bisf_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_host(req_host),
    .req_excl(req_excl), .req_addr(req_addr),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr),
    .ack_valid(ack_valid),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_host(rsp_host),
    .rsp_excl(rsp_excl), .rsp_data(rsp_data), .err_ack(err_ack)
  );

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_fn(mem_rd_addr);

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Filter model: set = addr[1:0], tag = addr[15:2], two ways per set
  bit          m_val [4][2];
  logic [13:0] m_tag [4][2];
  logic [3:0]  m_sh  [4][2];
  int          m_rr  [4];

  task automatic do_req(input int h, input bit ex, input logic [AW-1:0] a,
                        input int ack_mode, input int stall, input int rdy_mode,
                        input string force_lbl);
    int s = int'(a[1:0]);
    logic [13:0] t = a[15:2];
    int hw = -1;
    int fw = -1;
    logic [3:0] exp_mask = '0;
    logic [AW-1:0] exp_sa = a;
    string lbl;
    logic [3:0] seen = '0, hsd = '0, acked = '0, prev_stall = '0;
    bit bad_addr = 0, early = 0, busy_bad = 0, hold_bad = 0;
    bit data_bad = 0, host_bad = 0, got_rsp = 0;
    logic [DW-1:0] last_data = '0;
    int nstall = 0;
    bit done = 0;

    for (int w = 1; w >= 0; w--) begin
      if (m_val[s][w] && m_tag[s][w] == t) hw = w;
      if (!m_val[s][w]) fw = w;
    end
    if (hw >= 0) begin
      lbl = ex ? "R3" : "R2";
      if (ex) begin
        exp_mask = m_sh[s][hw] & ~(4'b1 << h);
        m_sh[s][hw] = 4'b1 << h;
      end else begin
        m_sh[s][hw] = m_sh[s][hw] | (4'b1 << h);
      end
    end else begin
      int w = fw;
      lbl = "R2";
      if (fw < 0) begin
        w = m_rr[s];
        lbl = "R7";
        exp_mask = m_sh[s][w];
        exp_sa = {m_tag[s][w], a[1:0]};
        m_rr[s] = (m_rr[s] + 1) % 2;
      end
      m_val[s][w] = 1;
      m_tag[s][w] = t;
      m_sh[s][w] = 4'b1 << h;
    end
    if (force_lbl != "") lbl = force_lbl;

    @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_host = 2'(h); req_excl = ex; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 300 && !done; cyc++) begin
      logic [3:0] cand;
      logic [3:0] ackv;
      snp_ready = (rdy_mode != 0) ? ((cyc % 2 != 0) ? 4'b0101 : 4'b1010) : 4'hF;
      if ((prev_stall & ~snp_valid) != 0) hold_bad = 1;
      if (snp_valid != 0 && snp_addr != exp_sa) bad_addr = 1;
      seen = seen | snp_valid;
      if (rsp_valid && acked != exp_mask) early = 1;
      cand = hsd & ~acked;
      if (ack_mode == 0) ackv = cand;
      else if (ack_mode == 1) ackv = cand & (~cand + 4'd1);
      else ackv = (cyc % 3 == 0) ? (cand & (~cand + 4'd1)) : 4'b0;
      ack_valid = ackv;
      acked = acked | ackv;
      hsd = hsd | (snp_valid & snp_ready);
      prev_stall = snp_valid & ~snp_ready;
      if (req_ready) busy_bad = 1;
      if (rsp_valid) begin
        if (got_rsp && rsp_data != last_data) data_bad = 1;
        if (rsp_data != mem_fn(a)) data_bad = 1;
        if (rsp_host != 2'(h) || rsp_excl != ex) host_bad = 1;
        last_data = rsp_data;
        got_rsp = 1;
        if (nstall >= stall) begin
          rsp_ready = 1'b1;
          done = 1;
        end
        nstall++;
      end
      @(negedge clk);
    end
    rsp_ready = 1'b0;
    ack_valid = '0;
    snp_ready = '1;
    check(done, "R5", "request completed", done, 1);
    check(seen == exp_mask, lbl, "snoop mask", seen, exp_mask);
    check(!bad_addr, lbl, "snoop address", snp_addr, exp_sa);
    check(!early, "R5", "response before last ack", acked, exp_mask);
    check(!busy_bad, "R8", "req_ready high while busy", 1, 0);
    check(!hold_bad, "R10", "snoop dropped before ready", 1, 0);
    check(!data_bad, "R9", "response data", last_data, mem_fn(a));
    check(!host_bad, "R9", "response host/excl", rsp_host, h);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < 2; w++) begin
        m_val[s][w] = 0; m_tag[s][w] = '0; m_sh[s][w] = '0;
      end
    end
    repeat (2) @(negedge clk);
    check(req_ready == 1 && snp_valid == 0 && rsp_valid == 0 && err_ack == 0,
          "R1", "outputs in reset", {req_ready, snp_valid, rsp_valid, err_ack}, 7'b1000000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1 && snp_valid == 0 && rsp_valid == 0 && err_ack == 0,
          "R1", "outputs after reset", {req_ready, snp_valid, rsp_valid, err_ack}, 7'b1000000);

    // R2: four shared readers of one line, no snoops
    for (int h = 0; h < 4; h++) do_req(h, 0, 16'h0040, 0, 0, 0, "R2");
    // R3: exclusive by host 2 snoops hosts 0,1,3; stalled response
    do_req(2, 1, 16'h0040, 0, 2, 1, "R3");
    // R2: shared read of an exclusively held line, no snoop
    do_req(0, 0, 16'h0040, 1, 0, 0, "R2");
    do_req(1, 1, 16'h0040, 2, 1, 0, "R3");
    // R4: host 1 now sole owner
    do_req(3, 1, 16'h0040, 0, 0, 1, "R4");

    // R6: unexpected ack while idle
    @(negedge clk);
    ack_valid = 4'b0100;
    @(negedge clk);
    ack_valid = '0;
    check(err_ack == 1'b1, "R6", "err_ack after stray ack", err_ack, 1);
    @(negedge clk);
    check(err_ack == 1'b0, "R6", "err_ack one cycle only", err_ack, 0);
    check(req_ready == 1'b1, "R6", "still idle after stray ack", req_ready, 1);
    do_req(0, 1, 16'h0040, 0, 0, 0, "R6");

    // R7: fill set 1, then conflict misses
    do_req(0, 0, 16'h0005, 0, 0, 0, "");
    do_req(1, 0, 16'h0005, 0, 0, 0, "");
    do_req(2, 1, 16'h0009, 0, 0, 0, "");
    do_req(3, 0, 16'h000D, 1, 0, 1, "R7");
    do_req(0, 0, 16'h0011, 0, 1, 0, "R7");

    // Sweep across hosts, modes, tags and back-pressure patterns
    for (int i = 0; i < 120; i++) begin
      logic [AW-1:0] a = AW'(((((i * 7) % 5) + 1) << 2) | (i % 2));
      do_req(i % 4, ((i / 3) % 2) == 1, a, i % 3, (i % 4 == 3) ? 3 : 0, (i / 5) % 2, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule